// File: doc/BRIEF.md
# Short and Long Branch and Skip Resolver

This block works out where a small 8-bit processor's program counter goes next after an opcode from one of its two control-flow rows. The short row is 0x30 to 0x3F. The long row is 0xC0 to 0xCF. The block takes these inputs:

- the opcode;
- the program counter, which already points at the byte after the opcode;
- the two bytes that follow the opcode;
- the condition inputs: the Q output flag, the carry flag, an "accumulator is zero" test, the interrupt-enable flag and four external flag lines.

It returns the next program counter and a taken indication. Instruction fetch and bus cycles belong to the enclosing core.

Each short-row opcode names one condition in its low three bits, and bit 3 inverts it. When a short branch is taken, only the low byte of the program counter is replaced. When it is not taken, the counter steps over the single address byte. A long branch loads all 16 bits, high byte first. When it is not taken, the counter steps over two bytes. A long skip steps over two bytes when its condition holds and otherwise falls through. Its condition sense is the inverse of the long branch in the same column.

The result is registered and appears one clock after the inputs are presented. The inputs are sampled on every clock.

Top module: `brsk_resolver`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `next_pc` is 0 and `taken` is 0. Otherwise each output reflects the inputs sampled at the previous rising clock edge.
- R2: Opcode 0x30 always sets `taken`=1 and `next_pc` = {`pc`[15:8], `byte0`}.
- R3: A short-row opcode 0x3n takes its branch when its condition holds. The condition for bits [2:0] is: 0 always, 1 `q_flag`, 2 `acc_zero`, 3 `carry`, 4..7 `ext_flag`[0..3]. Bit 3 set inverts the condition. When taken, `next_pc` = {`pc`[15:8], `byte0`} and `taken`=1.
- R4: A short-row opcode whose condition fails gives `next_pc` = `pc`+1 and `taken`=0. Opcode 0x38 always behaves this way.
- R5: Opcode 0xC0 sets `taken`=1 and `next_pc` = {`byte0`, `byte1`}, with `byte0` as the high byte.
- R6: The long conditional branches are taken to {`byte0`, `byte1`} with `taken`=1 under these conditions: 0xC1 `q_flag`, 0xC2 `acc_zero`, 0xC3 `carry`, 0xC9 !`q_flag`, 0xCA !`acc_zero`, 0xCB !`carry`.
- R7: A long branch that is not taken, and opcode 0xC8 in every case, gives `next_pc` = `pc`+2 and `taken`=0.
- R8: A long skip whose condition holds gives `next_pc` = `pc`+2 and `taken`=1. Otherwise it gives `next_pc` = `pc` and `taken`=0. The conditions are: 0xC5 !`q_flag`, 0xC6 !`acc_zero`, 0xC7 !`carry`, 0xCC `int_en`, 0xCD `q_flag`, 0xCE `acc_zero`, 0xCF `carry`.
- R9: Opcode 0xC4 gives `next_pc` = `pc` and `taken`=0, whatever the condition inputs are.
- R10: Any opcode outside 0x30..0x3F and 0xC0..0xCF gives `next_pc` = `pc` and `taken`=0.
- R11: Program counter increments wrap modulo 2^16. For example, 0xFFFF+1 gives 0x0000 and 0xFFFF+2 gives 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 8 | Opcode being resolved |
| pc | input | 16 | Program counter pointing past the opcode |
| byte0 | input | 8 | First byte after the opcode |
| byte1 | input | 8 | Second byte after the opcode |
| q_flag | input | 1 | Q output flag |
| carry | input | 1 | Carry/data flag |
| acc_zero | input | 1 | High when the accumulator is zero |
| int_en | input | 1 | Interrupt enable flag |
| ext_flag | input | 4 | External flags; bit 0 is the first line |
| next_pc | output | 16 | Resolved next program counter (registered) |
| taken | output | 1 | Branch taken or skip performed (registered) |

## Verification
The assertions assume that every input is a known value at each rising clock edge. They also assume that `rst` holds for at least one edge before the first check. Each property compares the outputs with the inputs from one cycle earlier, and it only does so when the previous edge was outside reset.

The stimulus changes the inputs only on falling clock edges and never leaves them undriven. Every row opcode is exercised with all condition inputs forced to 0 and then to 1, and random opcodes with mixed flags follow.

// File: rtl/brsk_pkg.sv
package brsk_pkg;

    localparam int BYTE_W = 8;
    localparam int PC_W   = 2 * BYTE_W;
    localparam int EF_N   = 4;
    localparam int EF_IW  = $clog2(EF_N);

    localparam logic [3:0] ROW_SHORT = 4'h3;
    localparam logic [3:0] ROW_LONG  = 4'hC;

    typedef enum logic [1:0] {
        FLOW_NONE,
        FLOW_SHORT,
        FLOW_LONG_BR,
        FLOW_LONG_SKIP
    } flow_e;

    typedef enum logic [2:0] {
        SEL_ALWAYS,
        SEL_NEVER,
        SEL_Q,
        SEL_ZERO,
        SEL_CARRY,
        SEL_IE,
        SEL_EXT
    } sel_e;

    typedef struct packed {
        flow_e            flow;
        sel_e             sel;
        logic [EF_IW-1:0] ext_idx;
        logic             invert;
    } dec_t;

endpackage

// File: rtl/brsk_decode.sv
module brsk_decode
    import brsk_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output dec_t              dec
);

    logic [3:0] row;
    logic [3:0] col;

    assign row = opcode[7:4];
    assign col = opcode[3:0];

    always_comb begin
        dec         = '0;
        dec.flow    = FLOW_NONE;
        dec.sel     = SEL_NEVER;
        dec.ext_idx = col[EF_IW-1:0];
        dec.invert  = 1'b0;
        unique case (row)
            ROW_SHORT: begin
                dec.flow   = FLOW_SHORT;
                dec.invert = col[3];
                if (col[2]) begin
                    dec.sel = SEL_EXT;
                end else begin
                    unique case (col[1:0])
                        2'd0: dec.sel = SEL_ALWAYS;
                        2'd1: dec.sel = SEL_Q;
                        2'd2: dec.sel = SEL_ZERO;
                        2'd3: dec.sel = SEL_CARRY;
                    endcase
                end
            end
            ROW_LONG: begin
                if (!col[2]) begin
                    dec.flow   = FLOW_LONG_BR;
                    dec.invert = col[3];
                    unique case (col[1:0])
                        2'd0: dec.sel = SEL_ALWAYS;
                        2'd1: dec.sel = SEL_Q;
                        2'd2: dec.sel = SEL_ZERO;
                        2'd3: dec.sel = SEL_CARRY;
                    endcase
                end else begin
                    dec.flow = FLOW_LONG_SKIP;
                    unique case (col[1:0])
                        2'd0: begin
                            dec.sel    = col[3] ? SEL_IE : SEL_NEVER;
                            dec.invert = 1'b0;
                        end
                        2'd1: begin
                            dec.sel    = SEL_Q;
                            dec.invert = !col[3];
                        end
                        2'd2: begin
                            dec.sel    = SEL_ZERO;
                            dec.invert = !col[3];
                        end
                        2'd3: begin
                            dec.sel    = SEL_CARRY;
                            dec.invert = !col[3];
                        end
                    endcase
                end
            end
            default: begin
                dec.flow = FLOW_NONE;
                dec.sel  = SEL_NEVER;
            end
        endcase
    end

endmodule

// File: rtl/brsk_cond.sv
module brsk_cond
    import brsk_pkg::*;
(
    input  dec_t            dec,
    input  logic            q_flag,
    input  logic            carry,
    input  logic            acc_zero,
    input  logic            int_en,
    input  logic [EF_N-1:0] ext_flag,
    output logic            hit
);

    logic raw;

    always_comb begin
        raw = 1'b0;
        unique case (dec.sel)
            SEL_ALWAYS: raw = 1'b1;
            SEL_NEVER:  raw = 1'b0;
            SEL_Q:      raw = q_flag;
            SEL_ZERO:   raw = acc_zero;
            SEL_CARRY:  raw = carry;
            SEL_IE:     raw = int_en;
            SEL_EXT:    raw = ext_flag[dec.ext_idx];
            default:    raw = 1'b0;
        endcase
        hit = raw ^ dec.invert;
    end

endmodule

// File: rtl/brsk_nextpc.sv
module brsk_nextpc
    import brsk_pkg::*;
(
    input  flow_e             flow,
    input  logic              hit,
    input  logic [PC_W-1:0]   pc,
    input  logic [BYTE_W-1:0] byte0,
    input  logic [BYTE_W-1:0] byte1,
    output logic [PC_W-1:0]   npc,
    output logic              tk
);

    logic [PC_W-1:0] step1;
    logic [PC_W-1:0] step2;

    assign step1 = pc + PC_W'(1);
    assign step2 = pc + PC_W'(2);

    always_comb begin
        npc = pc;
        tk  = 1'b0;
        unique case (flow)
            FLOW_NONE: begin
                npc = pc;
                tk  = 1'b0;
            end
            FLOW_SHORT: begin
                npc = hit ? {pc[PC_W-1:BYTE_W], byte0} : step1;
                tk  = hit;
            end
            FLOW_LONG_BR: begin
                npc = hit ? {byte0, byte1} : step2;
                tk  = hit;
            end
            FLOW_LONG_SKIP: begin
                npc = hit ? step2 : pc;
                tk  = hit;
            end
        endcase
    end

endmodule

// File: rtl/brsk_resolver.sv
module brsk_resolver
    import brsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] opcode,
    input  logic [PC_W-1:0]   pc,
    input  logic [BYTE_W-1:0] byte0,
    input  logic [BYTE_W-1:0] byte1,
    input  logic              q_flag,
    input  logic              carry,
    input  logic              acc_zero,
    input  logic              int_en,
    input  logic [EF_N-1:0]   ext_flag,
    output logic [PC_W-1:0]   next_pc,
    output logic              taken
);

    dec_t            dec;
    logic            hit;
    logic [PC_W-1:0] npc_d;
    logic            tk_d;

    brsk_decode u_decode (
        .opcode (opcode),
        .dec    (dec)
    );

    brsk_cond u_cond (
        .dec      (dec),
        .q_flag   (q_flag),
        .carry    (carry),
        .acc_zero (acc_zero),
        .int_en   (int_en),
        .ext_flag (ext_flag),
        .hit      (hit)
    );

    brsk_nextpc u_nextpc (
        .flow  (dec.flow),
        .hit   (hit),
        .pc    (pc),
        .byte0 (byte0),
        .byte1 (byte1),
        .npc   (npc_d),
        .tk    (tk_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc <= '0;
            taken   <= 1'b0;
        end else begin
            next_pc <= npc_d;
            taken   <= tk_d;
        end
    end

endmodule

// File: rtl/brsk_resolver_chk.sv
module brsk_resolver_chk
    import brsk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [BYTE_W-1:0] opcode,
    input logic [PC_W-1:0]   pc,
    input logic [BYTE_W-1:0] byte0,
    input logic [BYTE_W-1:0] byte1,
    input logic [PC_W-1:0]   next_pc,
    input logic              taken
);

    // R1: one clock after reset the outputs are clear
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (next_pc == '0) && !taken);

    // R2 and R3: a taken short branch keeps the high byte
    p_short_taken_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && ($past(opcode[7:4]) == ROW_SHORT) && taken
        |-> next_pc == {$past(pc[PC_W-1:BYTE_W]), $past(byte0)});

    // R4: a short branch that is not taken steps one byte
    p_short_fall_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && ($past(opcode[7:4]) == ROW_SHORT) && !taken
        |-> next_pc == $past(pc) + PC_W'(1));

    // R2: opcode 0x30 is always taken
    p_short_always_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && ($past(opcode) == 8'h30) |-> taken);

    // R5 and R6: a taken long branch loads both bytes
    p_long_taken_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && ($past(opcode[7:4]) == ROW_LONG) && !$past(opcode[2]) && taken
        |-> next_pc == {$past(byte0), $past(byte1)});

    // R7: a long branch that is not taken steps two bytes
    p_long_fall_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && ($past(opcode[7:4]) == ROW_LONG) && !$past(opcode[2]) && !taken
        |-> next_pc == $past(pc) + PC_W'(2));

    // R8: a long skip either steps two bytes or holds
    p_long_skip_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && ($past(opcode[7:4]) == ROW_LONG) && $past(opcode[2])
        |-> next_pc == (taken ? $past(pc) + PC_W'(2) : $past(pc)));

    // R9: the long-row no-operation never transfers control
    p_nop_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && ($past(opcode) == 8'hC4) |-> !taken && next_pc == $past(pc));

    // R10: opcodes outside both rows pass the counter through
    p_other_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && ($past(opcode[7:4]) != ROW_SHORT) && ($past(opcode[7:4]) != ROW_LONG)
        |-> !taken && next_pc == $past(pc));

endmodule

bind brsk_resolver brsk_resolver_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .opcode  (opcode),
    .pc      (pc),
    .byte0   (byte0),
    .byte1   (byte1),
    .next_pc (next_pc),
    .taken   (taken)
);

// File: tb/brsk_resolver_tb.sv
module brsk_resolver_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] pc = 16'h0000;
    logic [7:0]  byte0 = 8'h00;
    logic [7:0]  byte1 = 8'h00;
    logic        q_flag = 1'b0;
    logic        carry = 1'b0;
    logic        acc_zero = 1'b0;
    logic        int_en = 1'b0;
    logic [3:0]  ext_flag = 4'h0;
    logic [15:0] next_pc;
    logic        taken;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    brsk_resolver u_dut (
        .clk      (clk),
        .rst      (rst),
        .opcode   (opcode),
        .pc       (pc),
        .byte0    (byte0),
        .byte1    (byte1),
        .q_flag   (q_flag),
        .carry    (carry),
        .acc_zero (acc_zero),
        .int_en   (int_en),
        .ext_flag (ext_flag),
        .next_pc  (next_pc),
        .taken    (taken)
    );

    // Behavioural model built from the requirement text
    function automatic void model(input logic [7:0] op, input logic [15:0] p,
                                  input logic [7:0] b0, input logic [7:0] b1,
                                  input logic q, input logic df, input logic dz,
                                  input logic ie, input logic [3:0] ef,
                                  output logic [15:0] e_pc, output logic e_tk,
                                  output string tag);
        logic c;
        c    = 1'b0;
        e_pc = p;
        e_tk = 1'b0;
        tag  = "R10";
        if (op[7:4] == 4'h3) begin
            case (op)
                8'h30: c = 1'b1;
                8'h31: c = q;
                8'h32: c = dz;
                8'h33: c = df;
                8'h34: c = ef[0];
                8'h35: c = ef[1];
                8'h36: c = ef[2];
                8'h37: c = ef[3];
                8'h38: c = 1'b0;
                8'h39: c = !q;
                8'h3A: c = !dz;
                8'h3B: c = !df;
                8'h3C: c = !ef[0];
                8'h3D: c = !ef[1];
                8'h3E: c = !ef[2];
                default: c = !ef[3];
            endcase
            e_tk = c;
            e_pc = c ? {p[15:8], b0} : 16'(p + 1);
            tag  = (op == 8'h30) ? "R2" : (c ? "R3" : "R4");
        end else if (op[7:4] == 4'hC) begin
            case (op)
                8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC8, 8'hC9, 8'hCA, 8'hCB: begin
                    case (op)
                        8'hC0: c = 1'b1;
                        8'hC1: c = q;
                        8'hC2: c = dz;
                        8'hC3: c = df;
                        8'hC9: c = !q;
                        8'hCA: c = !dz;
                        8'hCB: c = !df;
                        default: c = 1'b0;
                    endcase
                    e_tk = c;
                    e_pc = c ? {b0, b1} : 16'(p + 2);
                    tag  = (op == 8'hC0) ? "R5" : (c ? "R6" : "R7");
                end
                8'hC4: begin
                    tag = "R9";
                end
                default: begin
                    case (op)
                        8'hC5: c = !q;
                        8'hC6: c = !dz;
                        8'hC7: c = !df;
                        8'hCC: c = ie;
                        8'hCD: c = q;
                        8'hCE: c = dz;
                        default: c = df;
                    endcase
                    e_tk = c;
                    e_pc = c ? 16'(p + 2) : p;
                    tag  = "R8";
                end
            endcase
        end
    endfunction

    task automatic check(input logic [15:0] e_pc, input logic e_tk, input string tag);
        n_vec++;
        if (next_pc !== e_pc || taken !== e_tk) begin
            n_fail++;
            $display("FAIL %s op=%02h: next_pc=%04h taken=%0b expected next_pc=%04h taken=%0b",
                     tag, opcode, next_pc, taken, e_pc, e_tk);
        end
    endtask

    // Drive on the falling edge; the result is registered at the next rising edge
    task automatic apply(input logic [7:0] op, input logic [15:0] p,
                         input logic [7:0] b0, input logic [7:0] b1,
                         input logic q, input logic df, input logic dz,
                         input logic ie, input logic [3:0] ef, input string force_tag);
        logic [15:0] e_pc;
        logic        e_tk;
        string       tag;
        @(negedge clk);
        opcode = op; pc = p; byte0 = b0; byte1 = b1;
        q_flag = q; carry = df; acc_zero = dz; int_en = ie; ext_flag = ef;
        model(op, p, b0, b1, q, df, dz, ie, ef, e_pc, e_tk, tag);
        if (force_tag != "") tag = force_tag;
        @(posedge clk);
        #1;
        check(e_pc, e_tk, tag);
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(16'h0000, 1'b0, "R1");
        @(negedge clk);
        rst = 1'b0;

        // Every row opcode with all conditions low, then all high
        for (int s = 0; s < 2; s++) begin
            for (int k = 0; k < 32; k++) begin
                logic [7:0] op;
                op = (k < 16) ? 8'(8'h30 + k) : 8'(8'hC0 + k - 16);
                apply(op, 16'h12F0 + 16'(k), 8'hA5, 8'h3C,
                      s[0], s[0], s[0], s[0], {4{s[0]}}, "");
            end
        end

        // One external flag at a time for the short row (R3)
        for (int f = 0; f < 4; f++) begin
            apply(8'(8'h34 + f), 16'h4410, 8'h77, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0,
                  4'(1 << f), "R3");
            apply(8'(8'h3C + f), 16'h4410, 8'h77, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0,
                  4'(1 << f), "R4");
        end

        // Counter wrap (R11)
        apply(8'h38, 16'hFFFF, 8'h11, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, "R11");
        apply(8'hC8, 16'hFFFF, 8'h11, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, "R11");
        apply(8'hCD, 16'hFFFE, 8'h11, 8'h22, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, "R11");
        apply(8'h39, 16'hFFFF, 8'h11, 8'h22, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, "R11");

        // Opcodes outside the rows (R10) and the no-operation with flags set (R9)
        apply(8'h00, 16'h2000, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, "R10");
        apply(8'hF8, 16'h2001, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, "R10");
        apply(8'h2F, 16'h2002, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, "R10");
        apply(8'hC4, 16'h2003, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, "R9");

        // Mixed random flags and opcodes
        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            logic [31:0] r;
            r  = $urandom;
            op = r[0] ? {4'h3, r[4:1]} : (r[5] ? {4'hC, r[9:6]} : r[17:10]);
            apply(op, 16'($urandom), 8'($urandom), 8'($urandom),
                  r[18], r[19], r[20], r[21], r[25:22], "");
        end

        // Reset in mid-stream clears the outputs again (R1)
        @(negedge clk);
        opcode = 8'h30; pc = 16'h5555; byte0 = 8'h99;
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(16'h0000, 1'b0, "R1");

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_vec++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule